// File: doc/BRIEF.md
# CSR Access Permission and Read-Modify-Write Gate

This block sits between instruction decode and a control/status register file. Each cycle in which `accValid` is high, it receives one access: a 12-bit register address, the requester's privilege level, a debug flag, write data and a write mask. In the same cycle it decides whether the access is legal and returns the register's current contents. The address itself carries most of the rules. Bits 9:8 give the lowest privilege allowed to touch the register, and bits 11:10 set to 3 mark it read-only. Further layers sit on top of these rules: per-counter enable masks, a supervisor-presence flag, a global counter switch, and a trap bit that guards the address-translation register.

A legal access with a nonzero mask merges the new data into the old value under the mask. The merged value is committed at the next clock edge and announced on a registered write strobe. An illegal access raises `illegal`, returns zero and never writes. The register storage behind the gate is a stand-in. It has four writable slots, a read-only identity register, and a 32-entry read-only counter window in which each counter reads as its own index.

Top module: `csr_gate`

## Requirements
- R1: An access with privilege below address bits 9:8 is illegal unless `debugMode` is 1. Privilege encodings are U=0, S=1 and M=3.
- R2: An access with a nonzero `wrMask` to an address whose bits 11:10 are 3 is illegal. A read (mask zero) of such an address stays legal; the identity register at 0xF14 reads `HART_ID`.
- R3: When a legal access hits a writable slot with a nonzero mask, `wrStrobe` is 1 after the next clock edge. At that point `wrAddr` holds the address and `wrValue` holds (old AND NOT mask) OR (data AND mask), and the slot reads the merged value from then on. A zero mask causes no strobe.
- R4: `rdData` is the value before the write. It is 0 whenever `illegal` is 1, and an illegal access causes no strobe and no change of stored state.
- R5: A counter address 0xC00..0xC1F read below M is illegal unless bit addr[4:0] of `mCtrEn` is set. A legal counter read returns addr[4:0].
- R6: A counter read at U additionally needs bit addr[4:0] of `sCtrEn` set. At S, `sCtrEn` has no effect.
- R7: With `ctrsOn` = 0, every counter address is illegal at any privilege.
- R8: With `hasSuper` = 0, every address whose bits 9:8 are 1 is illegal.
- R9: An address with no register behind it is illegal. The writable slots are 0x340, 0x341, 0x140 and 0x180.
- R10: Address 0x180 is illegal from S when `tvmBit` is 1, and stays legal from M.
- R11: During and right after reset, `wrStrobe` is 0 and every slot reads 0.
- R12: With `accValid` = 0, `illegal` is 0 and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 12 | Register address |
| privLvl | input | 2 | Requester privilege (U=0, S=1, M=3) |
| debugMode | input | 1 | Overrides the privilege check |
| wrData | input | XLEN | New data |
| wrMask | input | XLEN | Bits to replace; zero means read only |
| mCtrEn | input | 32 | Machine-level counter enables |
| sCtrEn | input | 32 | Supervisor-level counter enables |
| tvmBit | input | 1 | Traps translation-register access from S |
| hasSuper | input | 1 | Supervisor mode implemented |
| ctrsOn | input | 1 | Counters implemented |
| illegal | output | 1 | Access is illegal (combinational) |
| rdData | output | XLEN | Pre-write value (combinational) |
| wrStrobe | output | 1 | Registered write strobe |
| wrAddr | output | 12 | Address of the committed write |
| wrValue | output | XLEN | Merged value committed |

## Verification
A slot holding a wrong value shows up at the very next read of that address, because `rdData` comes straight from storage. It also shows up on the next partial write, where the merged `wrValue` carries the bad unmasked bits. A wrong legality decision is visible in the same cycle on `illegal`. When that error lets a write through, a stray `wrStrobe` appears one edge later, so the bench compares both the combinational verdict and the strobe of the following cycle against its own model for every access.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int CTR_NUM   = 32;
  localparam int CTR_IDX_W = $clog2(CTR_NUM);

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // writable stand-in slots; index 0 first
  localparam logic [NUM_SLOTS-1:0][11:0] SLOT_ADDR =
    {12'h180, 12'h140, 12'h341, 12'h340};

  localparam logic [11:0] ID_ADDR    = 12'hF14;
  localparam logic [11:0] XLATE_ADDR = 12'h180;
  localparam logic [11-CTR_IDX_W:0] CTR_BASE = 7'h60; // 0xC00 >> 5

  typedef struct packed {
    logic              legal;    // valid and legal this cycle
    logic              hitSlot;
    logic [SLOT_W-1:0] slot;
    logic              hitId;
    logic              hitCtr;
    logic              doWrite;
  } gate_strb_t;

endpackage

// File: rtl/csr_gate_ctrl.sv
module csr_gate_ctrl
  import csr_gate_pkg::*;
(
  input  logic        accValid,
  input  logic [11:0] accAddr,
  input  logic [1:0]  privLvl,
  input  logic        debugMode,
  input  logic        wrMaskNz,
  input  logic [CTR_NUM-1:0] mCtrEn,
  input  logic [CTR_NUM-1:0] sCtrEn,
  input  logic        tvmBit,
  input  logic        hasSuper,
  input  logic        ctrsOn,
  output gate_strb_t  strb,
  output logic        illegal
);

  logic              hitSlot, hitId, hitCtr;
  logic [SLOT_W-1:0] slotIdx;
  logic [1:0]        minPriv;
  logic              privOk, roViol, implOk, ctrOk, supOk, xlOk, legal;
  logic [CTR_IDX_W-1:0] ctrBit;

  always_comb begin
    hitSlot = 1'b0;
    slotIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (accAddr == SLOT_ADDR[i]) begin
        hitSlot = 1'b1;
        slotIdx = SLOT_W'(i);
      end
    end
  end

  assign hitId   = (accAddr == ID_ADDR);
  assign hitCtr  = (accAddr[11:CTR_IDX_W] == CTR_BASE);
  assign ctrBit  = accAddr[CTR_IDX_W-1:0];
  assign minPriv = accAddr[9:8];

  assign privOk = debugMode || (privLvl >= minPriv);
  assign roViol = (accAddr[11:10] == 2'b11) && wrMaskNz;
  assign implOk = hitSlot || hitId || hitCtr;
  assign supOk  = !((minPriv == PRIV_S) && !hasSuper);
  assign xlOk   = !((accAddr == XLATE_ADDR) && (privLvl == PRIV_S) && tvmBit);

  always_comb begin
    ctrOk = 1'b1;
    if (hitCtr) begin
      if (!ctrsOn) ctrOk = 1'b0;
      else begin
        if ((privLvl != PRIV_M) && !mCtrEn[ctrBit]) ctrOk = 1'b0;
        if ((privLvl == PRIV_U) && !sCtrEn[ctrBit]) ctrOk = 1'b0;
      end
    end
  end

  assign legal   = privOk && !roViol && implOk && ctrOk && supOk && xlOk;
  assign illegal = accValid && !legal;

  always_comb begin
    strb.legal   = accValid && legal;
    strb.hitSlot = hitSlot;
    strb.slot    = slotIdx;
    strb.hitId   = hitId;
    strb.hitCtr  = hitCtr;
    strb.doWrite = accValid && legal && wrMaskNz && hitSlot;
  end

endmodule

// File: rtl/csr_gate_dp.sv
module csr_gate_dp
  import csr_gate_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HART_ID = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  gate_strb_t      strb,
  input  logic [11:0]     accAddr,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] wrMask,
  output logic [XLEN-1:0] rdData,
  output logic            wrStrobe,
  output logic [11:0]     wrAddr,
  output logic [XLEN-1:0] wrValue
);

  logic [XLEN-1:0] slotQ [NUM_SLOTS];
  logic [XLEN-1:0] oldVal, merged;

  always_comb begin
    if (strb.hitSlot)     oldVal = slotQ[strb.slot];
    else if (strb.hitId)  oldVal = HART_ID;
    else if (strb.hitCtr) oldVal = XLEN'(accAddr[CTR_IDX_W-1:0]);
    else                  oldVal = '0;
  end

  assign rdData = strb.legal ? oldVal : '0;
  assign merged = (oldVal & ~wrMask) | (wrData & wrMask);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ[g] <= '0;
      else if (strb.doWrite && (strb.slot == SLOT_W'(g))) slotQ[g] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrValue  <= '0;
    end else begin
      wrStrobe <= strb.doWrite;
      if (strb.doWrite) begin
        wrAddr  <= accAddr;
        wrValue <= merged;
      end
    end
  end

  AST_MERGE_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrValue == (($past(rdData) & ~$past(wrMask)) | ($past(wrData) & $past(wrMask))))); // R3

endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import csr_gate_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HART_ID = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [11:0]     accAddr,
  input  logic [1:0]      privLvl,
  input  logic            debugMode,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] wrMask,
  input  logic [31:0]     mCtrEn,
  input  logic [31:0]     sCtrEn,
  input  logic            tvmBit,
  input  logic            hasSuper,
  input  logic            ctrsOn,
  output logic            illegal,
  output logic [XLEN-1:0] rdData,
  output logic            wrStrobe,
  output logic [11:0]     wrAddr,
  output logic [XLEN-1:0] wrValue
);

  gate_strb_t strb;

  csr_gate_ctrl ctrl_i (
    .accValid (accValid),
    .accAddr  (accAddr),
    .privLvl  (privLvl),
    .debugMode(debugMode),
    .wrMaskNz (|wrMask),
    .mCtrEn   (mCtrEn),
    .sCtrEn   (sCtrEn),
    .tvmBit   (tvmBit),
    .hasSuper (hasSuper),
    .ctrsOn   (ctrsOn),
    .strb     (strb),
    .illegal  (illegal)
  );

  csr_gate_dp #(.XLEN(XLEN), .HART_ID(HART_ID)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .accAddr (accAddr),
    .wrData  (wrData),
    .wrMask  (wrMask),
    .rdData  (rdData),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr),
    .wrValue (wrValue)
  );

  AST_STROBE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(accValid && !illegal && (wrMask != '0))); // R3
  AST_PRIV_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($past(debugMode) || ($past(privLvl) >= wrAddr[9:8]))); // R1
  AST_RO_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrAddr[11:10] != 2'b11)); // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (rdData == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !illegal); // R12

endmodule

// File: tb/csr_gate_tb.sv
module csr_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 20000;

  logic clk = 0, rstN = 0;
  logic accValid = 0, debugMode = 0, tvmBit = 0, hasSuper = 1, ctrsOn = 1;
  logic [11:0] accAddr = 0;
  logic [1:0]  privLvl = 3;
  logic [31:0] wrData = 0, wrMask = 0, mCtrEn = 0, sCtrEn = 0;
  logic illegal, wrStrobe;
  logic [31:0] rdData, wrValue;
  logic [11:0] wrAddr;

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  logic [31:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_gate dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .privLvl(privLvl), .debugMode(debugMode), .wrData(wrData), .wrMask(wrMask),
    .mCtrEn(mCtrEn), .sCtrEn(sCtrEn), .tvmBit(tvmBit), .hasSuper(hasSuper),
    .ctrsOn(ctrsOn), .illegal(illegal), .rdData(rdData), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrValue(wrValue)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit isCtr(logic [11:0] a);
    return (a >= 12'hC00) && (a <= 12'hC1F);
  endfunction

  function automatic bit modelIllegal(logic [11:0] a, logic [1:0] p, logic dbg, logic [31:0] m);
    int need = a[9:8];
    int idx = a[4:0];
    if (!dbg && p < need) return 1;
    if (a[11:10] == 2'b11 && m != 0) return 1;
    if (!(mem.exists(a) || a == 12'hF14 || isCtr(a))) return 1;
    if (isCtr(a)) begin
      if (!ctrsOn) return 1;
      if (p != 3 && !mCtrEn[idx]) return 1;
      if (p == 0 && !sCtrEn[idx]) return 1;
    end
    if (need == 1 && !hasSuper) return 1;
    if (a == 12'h180 && p == 1 && tvmBit) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    if (mem.exists(a)) return mem[a];
    if (a == 12'hF14) return 32'd5;
    if (isCtr(a)) return {27'd0, a[4:0]};
    return 0;
  endfunction

  task automatic doAcc(string req, logic [11:0] a, logic [1:0] p, logic dbg,
                       logic [31:0] d, logic [31:0] m);
    logic eIll, eStb;
    logic [31:0] eRd, eVal;
    @(negedge clk);
    accValid = 1; accAddr = a; privLvl = p; debugMode = dbg; wrData = d; wrMask = m;
    #1;
    eIll = modelIllegal(a, p, dbg, m);
    eRd  = eIll ? 32'd0 : modelRead(a);
    chk({req, " illegal"}, {31'd0, illegal}, {31'd0, eIll});
    chk({req, " rdData"}, rdData, eRd);
    eStb = !eIll && m != 0 && mem.exists(a);
    eVal = (eRd & ~m) | (d & m);
    @(posedge clk); #1;
    accValid = 0; wrMask = 0; debugMode = 0;
    if (eStb) mem[a] = eVal;
    chk({req, " wrStrobe"}, {31'd0, wrStrobe}, {31'd0, eStb});
    if (eStb) begin
      chk({req, " wrAddr"}, {20'd0, wrAddr}, {20'd0, a});
      chk({req, " wrValue"}, wrValue, eVal);
    end
  endtask

  initial begin
    #(CLK_PERIOD * TIMEOUT);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    mem[12'h340] = 0; mem[12'h341] = 0; mem[12'h140] = 0; mem[12'h180] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 strobe in reset", {31'd0, wrStrobe}, 0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    chk("R11 strobe after reset", {31'd0, wrStrobe}, 0);
    chk("R12 idle illegal", {31'd0, illegal}, 0);
    doAcc("R11 slot zero", 12'h341, 3, 0, 0, 0);
    // R12: idle with an otherwise illegal pattern
    @(negedge clk); accAddr = 12'h7FF; privLvl = 0; wrMask = 32'hFFFF_FFFF; #1;
    chk("R12 idle no illegal", {31'd0, illegal}, 0);
    @(posedge clk); #1;
    chk("R12 idle no strobe", {31'd0, wrStrobe}, 0);
    wrMask = 0;
    doAcc("R3 full write", 12'h340, 3, 0, 32'hA5A5_A5A5, 32'hFFFF_FFFF);
    doAcc("R3 readback", 12'h340, 3, 0, 32'h1234_5678, 0);
    doAcc("R4 partial old value", 12'h340, 3, 0, 32'h0, 32'h0000_FFFF);
    doAcc("R3 partial readback", 12'h340, 3, 0, 0, 0);
    doAcc("R1 user to machine", 12'h340, 0, 0, 32'hFFFF, 32'hFFFF);
    doAcc("R4 no change after illegal", 12'h340, 3, 0, 0, 0);
    doAcc("R1 debug override", 12'h340, 0, 1, 32'h0F0F_0000, 32'hFFFF_0000);
    doAcc("R1 super at super", 12'h140, 1, 0, 32'hCAFE_0001, 32'hFFFF_FFFF);
    doAcc("R1 user to super", 12'h140, 0, 0, 32'h1, 32'h1);
    doAcc("R2 write id", 12'hF14, 3, 0, 32'h1, 32'h1);
    doAcc("R2 read id", 12'hF14, 3, 0, 0, 0);
    doAcc("R2 write counter", 12'hC03, 3, 0, 32'h1, 32'h1);
    mEn_set(32'h0000_0008, 32'h0);
    doAcc("R5 super counter enabled", 12'hC03, 1, 0, 0, 0);
    doAcc("R6 user needs super enable", 12'hC03, 0, 0, 0, 0);
    mEn_set(32'h0000_0008, 32'h0000_0008);
    doAcc("R6 user both enabled", 12'hC03, 0, 0, 0, 0);
    doAcc("R5 user unenabled counter", 12'hC04, 0, 0, 0, 0);
    doAcc("R5 super unenabled counter", 12'hC04, 1, 0, 0, 0);
    doAcc("R5 machine ignores enables", 12'hC1F, 3, 0, 0, 0);
    mEn_set(32'hFFFF_FFFF, 32'h0);
    doAcc("R6 super ignores sCtrEn", 12'hC10, 1, 0, 0, 0);
    ctrsOn = 0;
    doAcc("R7 counters off machine", 12'hC03, 3, 0, 0, 0);
    doAcc("R7 counters off super", 12'hC00, 1, 0, 0, 0);
    ctrsOn = 1;
    hasSuper = 0;
    doAcc("R8 no super machine read", 12'h140, 3, 0, 0, 0);
    doAcc("R8 no super xlate write", 12'h180, 3, 0, 32'h1, 32'h1);
    hasSuper = 1;
    doAcc("R9 unimplemented 0x342", 12'h342, 3, 0, 0, 0);
    doAcc("R9 unimplemented 0xC20", 12'hC20, 3, 0, 0, 0);
    tvmBit = 1;
    doAcc("R10 super xlate trapped", 12'h180, 1, 0, 32'h8000_0001, 32'hFFFF_FFFF);
    doAcc("R10 machine xlate ok", 12'h180, 3, 0, 32'h8000_0001, 32'hFFFF_FFFF);
    tvmBit = 0;
    doAcc("R10 super xlate untrapped", 12'h180, 1, 0, 32'h0000_00F0, 32'h0000_00FF);
    doAcc("R3 zero mask no strobe", 12'h341, 3, 0, 32'hFFFF_FFFF, 0);
    doAcc("R4 readback slot", 12'h180, 3, 0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  task automatic mEn_set(logic [31:0] mv, logic [31:0] sv);
    @(negedge clk);
    mCtrEn = mv; sCtrEn = sv;
  endtask

endmodule